// File: doc/BRIEF.md
# Commit Trap Sequencer

This block sits on the retire side of an out-of-order core. It watches the instruction at the head of the reorder buffer. When that instruction carries a fault, the block turns it into a trap. It first makes sure the store path has drained and that nothing else retired in the same cycle. It then signals the architectural trap unit with a one-cycle strobe and the fault cause. From that point it blocks retirement while a programmable delay runs out.

When the delay expires, the block arms an internal squash flag. On the following cycle it broadcasts a squash of everything in flight. The broadcast carries the redirect address supplied by the trap unit, a done sequence number and a reset value for the youngest sequence number. The block then holds a ROB-squashing indication until the buffer reports empty, and after that returns to normal retirement.

A fault marked as a syscall-retry class uses a second latency setting in place of the normal one. The reorder buffer, the CSR update logic and the fetch redirect path are outside this block.

Top module: `trap_seq`

## Requirements
- R1: A faulting valid head is never taken as a trap in a cycle where `stores_drained` is low. The fault is retried on later cycles.
- R2: A faulting valid head is never taken as a trap in a cycle where `retired_cnt` is non-zero. The fault is retried on a later cycle when the count is zero.
- R3: `head_done` is high in the cycle after a valid head that is neither faulting nor a store. It is high in the cycle after a faulting head only when that head is taken as a trap. It stays low for a non-faulting store head.
- R4: When a trap is taken, the following cycle shows `trap_take` high for exactly one cycle, with `trap_cause` equal to the head cause. `trap_pending` and `trap_inflight` are set in that same cycle.
- R5: While `trap_pending` is high, `retire_hold` is high and no head is marked done, apart from the faulting head in the `trap_take` cycle.
- R6: For a fault with `head_retry` low, `squash_all` rises exactly `lat_normal` + 2 cycles after `trap_take` was high.
- R7: For a fault with `head_retry` high, the delay uses `lat_retry` in place of `lat_normal`, so `squash_all` rises `lat_retry` + 2 cycles after `trap_take`.
- R8: `squash_all` and `trap_squash` are one-cycle pulses that occur together. In that cycle `rob_squashing` is high, `trap_pending` and `trap_inflight` are low, and `redirect_pc` equals `handler_pc`.
- R9: With the squash, `squash_seq` equals `head_seq` minus one (modulo 2^SEQ_W). If `rob_empty` is high, `squash_seq` equals `last_seq` instead. `youngest_seq` equals `last_seq`.
- R10: `rob_squashing` and `retire_hold` stay high after the squash until a cycle with `rob_empty` high. The following cycle both are low.
- R11: After synchronous reset every output strobe, flag and hold is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| head_vld | input | 1 | ROB head holds an instruction |
| head_fault | input | 1 | Head instruction carries a fault |
| head_store | input | 1 | Head instruction is a store |
| head_retry | input | 1 | Fault is of the syscall-retry class |
| head_cause | input | CAUSE_W | Fault cause code of the head |
| head_seq | input | SEQ_W | Sequence number of the head |
| rob_empty | input | 1 | Reorder buffer holds no entries |
| last_seq | input | SEQ_W | Last committed sequence number |
| stores_drained | input | 1 | No older store outstanding |
| retired_cnt | input | RET_W | Instructions already retired this cycle |
| handler_pc | input | PC_W | Trap handler address from the trap unit |
| lat_normal | input | LAT_W | Delay for ordinary faults, in cycles |
| lat_retry | input | LAT_W | Delay for syscall-retry faults, in cycles |
| trap_take | output | 1 | One-cycle trap invoke strobe |
| trap_cause | output | CAUSE_W | Cause passed with the strobe |
| head_done | output | 1 | Head marked completed |
| trap_pending | output | 1 | Trap taken, squash not yet issued |
| trap_inflight | output | 1 | Trap event outstanding |
| retire_hold | output | 1 | Retirement blocked |
| squash_all | output | 1 | Squash every in-flight instruction |
| rob_squashing | output | 1 | ROB is squashing |
| trap_squash | output | 1 | Squash originates from a trap |
| squash_seq | output | SEQ_W | Done sequence number of the squash |
| youngest_seq | output | SEQ_W | Youngest sequence number after squash |
| redirect_pc | output | PC_W | Restart address sent with the squash |

## Verification
Every cycle the assertions check the gating of the trap strobe against the drain flag and the retired count of the previous cycle. They also check that the strobe and the squash are single pulses, the flag states around both pulses, and the absence of completions during the pending window. The exact delay under each latency setting can only be shown by the bench's timed scenarios. The same holds for the choice between the head-minus-one and last-committed squash numbers, the redirect value, and the return to running once the buffer empties.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_PEND  = 2'd1,
    ST_FIRE  = 2'd2,
    ST_DRAIN = 2'd3
  } trap_st_e;
endpackage

// File: rtl/trap_gate.sv
module trap_gate #(
  parameter int RET_W = 3
) (
  input  logic             running,
  input  logic             head_vld,
  input  logic             head_fault,
  input  logic             head_store,
  input  logic             stores_drained,
  input  logic [RET_W-1:0] retired_cnt,
  output logic             take,
  output logic             complete
);
  logic clean_retire;
  always_comb begin
    take         = running && head_vld && head_fault && stores_drained &&
                   (retired_cnt == '0);
    clean_retire = running && head_vld && !head_fault && !head_store;
    complete     = clean_retire || take;
  end
endmodule

// File: rtl/trap_countdown.sv
module trap_countdown #(
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             use_alt,
  input  logic [LAT_W-1:0] lat_a,
  input  logic [LAT_W-1:0] lat_b,
  input  logic             tick,
  output logic             expired
);
  logic [LAT_W-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= use_alt ? lat_b : lat_a;
    else if (tick && cnt != '0)
      cnt <= cnt - 1'b1;
  end
  assign expired = (cnt == '0);
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int SEQ_W   = 16,
  parameter int PC_W    = 32,
  parameter int CAUSE_W = 5,
  parameter int LAT_W   = 6,
  parameter int RET_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               head_vld,
  input  logic               head_fault,
  input  logic               head_store,
  input  logic               head_retry,
  input  logic [CAUSE_W-1:0] head_cause,
  input  logic [SEQ_W-1:0]   head_seq,
  input  logic               rob_empty,
  input  logic [SEQ_W-1:0]   last_seq,
  input  logic               stores_drained,
  input  logic [RET_W-1:0]   retired_cnt,
  input  logic [PC_W-1:0]    handler_pc,
  input  logic [LAT_W-1:0]   lat_normal,
  input  logic [LAT_W-1:0]   lat_retry,
  output logic               trap_take,
  output logic [CAUSE_W-1:0] trap_cause,
  output logic               head_done,
  output logic               trap_pending,
  output logic               trap_inflight,
  output logic               retire_hold,
  output logic               squash_all,
  output logic               rob_squashing,
  output logic               trap_squash,
  output logic [SEQ_W-1:0]   squash_seq,
  output logic [SEQ_W-1:0]   youngest_seq,
  output logic [PC_W-1:0]    redirect_pc
);
  localparam logic [SEQ_W-1:0] SEQ_ONE = {{(SEQ_W-1){1'b0}}, 1'b1};

  trap_st_e st;
  logic     take, complete, expired, sq_flag;

  trap_gate #(.RET_W(RET_W)) u_gate (
    .running        (st == ST_RUN),
    .head_vld       (head_vld),
    .head_fault     (head_fault),
    .head_store     (head_store),
    .stores_drained (stores_drained),
    .retired_cnt    (retired_cnt),
    .take           (take),
    .complete       (complete)
  );

  trap_countdown #(.LAT_W(LAT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (take),
    .use_alt (head_retry),
    .lat_a   (lat_normal),
    .lat_b   (lat_retry),
    .tick    (st == ST_PEND),
    .expired (expired)
  );

  // squash flag armed once the countdown has run out
  assign sq_flag     = (st == ST_FIRE);
  assign retire_hold = (st != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_RUN;
      trap_take     <= 1'b0;
      trap_cause    <= '0;
      head_done     <= 1'b0;
      trap_pending  <= 1'b0;
      trap_inflight <= 1'b0;
      squash_all    <= 1'b0;
      rob_squashing <= 1'b0;
      trap_squash   <= 1'b0;
      squash_seq    <= '0;
      youngest_seq  <= '0;
      redirect_pc   <= '0;
    end else begin
      trap_take   <= 1'b0;
      squash_all  <= 1'b0;
      trap_squash <= 1'b0;
      head_done   <= complete;
      unique case (st)
        ST_RUN: begin
          if (take) begin
            trap_take     <= 1'b1;
            trap_cause    <= head_cause;
            trap_pending  <= 1'b1;
            trap_inflight <= 1'b1;
            st            <= ST_PEND;
          end
        end
        ST_PEND: begin
          if (expired) st <= ST_FIRE;
        end
        ST_FIRE: begin
          if (sq_flag) begin
            squash_all    <= 1'b1;
            trap_squash   <= 1'b1;
            rob_squashing <= 1'b1;
            trap_pending  <= 1'b0;
            trap_inflight <= 1'b0;
            squash_seq    <= rob_empty ? last_seq : head_seq - SEQ_ONE;
            youngest_seq  <= last_seq;
            redirect_pc   <= handler_pc;
            st            <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (rob_empty) begin
            rob_squashing <= 1'b0;
            st            <= ST_RUN;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk #(
  parameter int RET_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             stores_drained,
  input logic [RET_W-1:0] retired_cnt,
  input logic             trap_take,
  input logic             head_done,
  input logic             trap_pending,
  input logic             trap_inflight,
  input logic             retire_hold,
  input logic             squash_all,
  input logic             rob_squashing,
  input logic             trap_squash
);
  AST_TAKE_DRAINED: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> $past(stores_drained)); // R1
  AST_TAKE_NO_RETIRE: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> ($past(retired_cnt) == '0)); // R2
  AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    trap_take |=> !trap_take); // R4
  AST_TAKE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    trap_take |-> (trap_pending && trap_inflight)); // R4
  AST_PEND_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (trap_pending && !trap_take) |-> (!head_done && retire_hold)); // R5
  AST_SQUASH_STATE: assert property (@(posedge clk) disable iff (rst)
    squash_all |-> (trap_squash && rob_squashing && !trap_pending && !trap_inflight)); // R8
  AST_SQUASH_PULSE: assert property (@(posedge clk) disable iff (rst)
    squash_all |=> !squash_all); // R8
  AST_ROBSQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    rob_squashing |-> retire_hold); // R10
endmodule

bind trap_seq trap_seq_chk #(.RET_W(RET_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .stores_drained (stores_drained),
  .retired_cnt    (retired_cnt),
  .trap_take      (trap_take),
  .head_done      (head_done),
  .trap_pending   (trap_pending),
  .trap_inflight  (trap_inflight),
  .retire_hold    (retire_hold),
  .squash_all     (squash_all),
  .rob_squashing  (rob_squashing),
  .trap_squash    (trap_squash)
);

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;
  localparam int SEQ_W = 16, PC_W = 32, CAUSE_W = 5, LAT_W = 6, RET_W = 3;

  logic clk = 1'b0;
  logic rst;
  logic head_vld, head_fault, head_store, head_retry, rob_empty, stores_drained;
  logic [CAUSE_W-1:0] head_cause;
  logic [SEQ_W-1:0]   head_seq, last_seq;
  logic [RET_W-1:0]   retired_cnt;
  logic [PC_W-1:0]    handler_pc;
  logic [LAT_W-1:0]   lat_normal, lat_retry;
  logic trap_take, head_done, trap_pending, trap_inflight, retire_hold;
  logic squash_all, rob_squashing, trap_squash;
  logic [CAUSE_W-1:0] trap_cause;
  logic [SEQ_W-1:0]   squash_seq, youngest_seq;
  logic [PC_W-1:0]    redirect_pc;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  trap_seq #(.SEQ_W(SEQ_W), .PC_W(PC_W), .CAUSE_W(CAUSE_W), .LAT_W(LAT_W), .RET_W(RET_W)) u0 (
    .clk(clk), .rst(rst), .head_vld(head_vld), .head_fault(head_fault),
    .head_store(head_store), .head_retry(head_retry), .head_cause(head_cause),
    .head_seq(head_seq), .rob_empty(rob_empty), .last_seq(last_seq),
    .stores_drained(stores_drained), .retired_cnt(retired_cnt),
    .handler_pc(handler_pc), .lat_normal(lat_normal), .lat_retry(lat_retry),
    .trap_take(trap_take), .trap_cause(trap_cause), .head_done(head_done),
    .trap_pending(trap_pending), .trap_inflight(trap_inflight),
    .retire_hold(retire_hold), .squash_all(squash_all),
    .rob_squashing(rob_squashing), .trap_squash(trap_squash),
    .squash_seq(squash_seq), .youngest_seq(youngest_seq), .redirect_pc(redirect_pc)
  );

  // {fault, store, drained, retired_nonzero, expect_take, expect_done}
  localparam logic [5:0] VEC [8] = '{
    6'b0010_01, 6'b0110_00, 6'b1000_00, 6'b1011_00,
    6'b1001_00, 6'b1010_11, 6'b0011_01, 6'b1110_11
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #2;
  endtask

  task automatic recover();
    @(negedge clk);
    head_vld = 0; head_fault = 0; rob_empty = 1;
    for (int i = 0; i < 60 && retire_hold; i++) cyc();
    @(negedge clk);
    rob_empty = 0;
  endtask

  // returns cycles from trap_take to squash_all
  task automatic wait_squash(output int n);
    n = 0;
    for (int i = 0; i < 100 && !squash_all; i++) begin cyc(); n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst = 1; head_vld = 0; head_fault = 0; head_store = 0; head_retry = 0;
    head_cause = 5'd4; head_seq = 16'd100; rob_empty = 0; last_seq = 16'd90;
    stores_drained = 1; retired_cnt = 0; handler_pc = 32'h8000_0100;
    lat_normal = 6'd2; lat_retry = 6'd7;
    repeat (3) cyc();
    check("R11 take", trap_take, 0);
    check("R11 pending", trap_pending, 0);
    check("R11 hold", retire_hold, 0);
    check("R11 squash", squash_all | rob_squashing | trap_squash | trap_inflight | head_done, 0);
    @(negedge clk); rst = 0;

    // table walk: R1 R2 R3
    foreach (VEC[k]) begin
      @(negedge clk);
      head_vld = 1; head_fault = VEC[k][5]; head_store = VEC[k][4];
      stores_drained = VEC[k][3]; retired_cnt = VEC[k][2] ? 3'd2 : 3'd0;
      cyc();
      check($sformatf("R1/R2 take vec%0d", k), trap_take, VEC[k][1]);
      check($sformatf("R3 done vec%0d", k), head_done, VEC[k][0]);
      if (VEC[k][1]) begin
        @(negedge clk); head_vld = 0; head_fault = 0;
        wait_squash(n);
      end
      recover();
      @(negedge clk); head_vld = 0; retired_cnt = 0; stores_drained = 1; head_store = 0;
    end

    // R1 retry: blocked fault taken once drained
    @(negedge clk);
    head_vld = 1; head_fault = 1; stores_drained = 0; head_cause = 5'd6; lat_normal = 6'd3;
    head_seq = 16'd200; last_seq = 16'd150;
    repeat (3) begin cyc(); check("R1 held while stores", trap_take, 0); end
    @(negedge clk); stores_drained = 1;
    cyc();
    check("R4 take", trap_take, 1);
    check("R4 cause", trap_cause, 6);
    check("R4 pending", trap_pending, 1);
    check("R4 inflight", trap_inflight, 1);
    // R5: non-faulting head presented during pending
    @(negedge clk); head_fault = 0; head_store = 0;
    cyc();
    check("R4 pulse", trap_take, 0);
    check("R5 no done", head_done, 0);
    check("R5 hold", retire_hold, 1);
    n = 1;
    for (int i = 0; i < 100 && !squash_all; i++) begin cyc(); n++; end
    check("R6 latency", n, 5);
    check("R8 trap_squash", trap_squash, 1);
    check("R8 rob_squashing", rob_squashing, 1);
    check("R8 pending clear", trap_pending | trap_inflight, 0);
    check("R8 redirect", redirect_pc, 32'h8000_0100);
    check("R9 squash_seq", squash_seq, 16'd199);
    check("R9 youngest", youngest_seq, 16'd150);
    @(negedge clk); head_vld = 0;
    cyc();
    check("R8 squash pulse", squash_all | trap_squash, 0);
    repeat (3) cyc();
    check("R10 still squashing", rob_squashing, 1);
    check("R10 still hold", retire_hold, 1);
    @(negedge clk); rob_empty = 1;
    cyc();
    check("R10 robsq released", rob_squashing, 0);
    check("R10 hold released", retire_hold, 0);
    @(negedge clk); rob_empty = 0;

    // R2 retry: retired count blocks, then zero allows
    @(negedge clk);
    head_vld = 1; head_fault = 1; retired_cnt = 3'd1; head_retry = 1;
    cyc(); check("R2 held while retired", trap_take, 0);
    @(negedge clk); retired_cnt = 0;
    cyc(); check("R2 taken later", trap_take, 1);
    @(negedge clk); head_vld = 0; head_fault = 0; rob_empty = 1; last_seq = 16'd77;
    wait_squash(n);
    check("R7 retry latency", n, 9);
    check("R9 empty rob seq", squash_seq, 16'd77);
    recover();

    // zero latency and sequence wrap
    @(negedge clk);
    head_retry = 0; lat_normal = 0; head_vld = 1; head_fault = 1; head_seq = 16'd0;
    cyc(); check("R4 take lat0", trap_take, 1);
    @(negedge clk); head_vld = 0; head_fault = 0;
    wait_squash(n);
    check("R6 zero latency", n, 2);
    check("R9 wrap seq", squash_seq, 16'hFFFF);
    recover();

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule